// File: doc/BRIEF.md
# Receive Retiming and Squelch Control

This block sits at the output of a line receiver and retimes the dual-rail receive data (one positive rail and one negative rail per lane) onto the recovered receive clock. A configuration bit picks the capture edge. When set, the rails are sampled on the rising edge of the recovered clock. When clear, they are sampled on the falling edge. The retimed rails and an output clock go on to the framing logic downstream.

When the digital loss-of-signal alarm is raised and the shut-down control is set, the block squelches its outputs. Both rails of every lane are forced to an idle level, and a separate level bit chooses whether that level is high or low. The output clock is handed over from the recovered clock to a free-running local clock. A two-stage handover lets only one source drive the output at a time. The alarm input is asynchronous. It is synchronized into the free-running clock domain before it gates anything.

When the shut-down control is clear, the alarm has no effect. The three controls sit in bits 7 (shut-down), 6 (capture edge) and 5 (idle level) of an 8-bit configuration word. The other five bits are spare.

Top module: `rx_retime_squelch`

## Requirements
- R1: With cfg_reg bit 6 = 1 and no squelch, each lane of rail_p_out and rail_n_out shows the value its rail input had at the most recent rising edge of rec_clk.
- R2: With cfg_reg bit 6 = 0 and no squelch, each lane of rail_p_out and rail_n_out shows the value its rail input had at the most recent falling edge of rec_clk.
- R3: With cfg_reg bit 7 = 1 and dlos_in held high, every bit of rail_p_out and rail_n_out equals cfg_reg bit 5 (1 = idle high, 0 = idle low), whatever the rail inputs.
- R4: In the squelch condition of R3, clk_out follows ref_clk.
- R5: With cfg_reg bit 7 = 0, the rails follow R1/R2 and clk_out follows rec_clk, whether dlos_in is high or low.
- R6: clk_out never shows a high or low pulse shorter than the shorter half-period of rec_clk and ref_clk, including across every switch between the two sources.
- R7: A change of dlos_in (with bit 7 = 1) reaches the data outputs at the third rising edge of ref_clk after the change, and not at the second, both when squelch starts and when it ends.
- R8: While rst is high, rail_p_out and rail_n_out are all 0 and clk_out stays low. After reset, clk_out follows rec_clk.
- R9: cfg_reg bits 4 to 0 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Synchronous active-high reset, applied in both clock domains |
| rec_clk | input | 1 | Recovered receive clock |
| ref_clk | input | 1 | Free-running local clock |
| cfg_reg | input | 8 | Configuration word: bit 7 shut-down, bit 6 capture edge, bit 5 idle level |
| dlos_in | input | 1 | Digital loss-of-signal alarm, asynchronous |
| rail_p_in | input | LANES | Positive-rail receive data |
| rail_n_in | input | LANES | Negative-rail receive data |
| rail_p_out | output | LANES | Retimed or squelched positive rail |
| rail_n_out | output | LANES | Retimed or squelched negative rail |
| clk_out | output | 1 | Output clock: rec_clk normally, ref_clk during squelch |

## Verification
The retiming path is driven so that the rail inputs carry one value across the rising edge of rec_clk and a different value across the falling edge. Because the two values differ, the output shows which edge did the capture. Patterns with the rails equal, opposite and all-zero or all-one separate lane and rail mix-ups from edge mix-ups. The squelch is tried with inputs opposite to the idle level under both level settings, and with the alarm high but shut-down clear. The output clock source is identified by counting clk_out edges over a fixed window, since the two clocks have different rates. The alarm latency is probed on the second and third ref_clk edges in both directions, to separate a correct two-stage synchronizer from a missing or extra stage.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int CFG_W     = 8;
  localparam int SHUT_BIT  = 7;
  localparam int EDGE_BIT  = 6;
  localparam int LEVEL_BIT = 5;

  typedef struct packed {
    logic shut_en;    // squelch allowed on alarm
    logic rise_sel;   // 1: capture on rising edge
    logic idle_high;  // idle level when squelched
  } rxr_ctl_t;

  function automatic rxr_ctl_t rxr_decode(input logic [CFG_W-1:0] word);
    rxr_ctl_t c;
    c.shut_en   = word[SHUT_BIT];
    c.rise_sel  = word[EDGE_BIT];
    c.idle_high = word[LEVEL_BIT];
    return c;
  endfunction
endpackage

// File: rtl/rxr_edge_capture.sv
module rxr_edge_capture #(
  parameter int LANES = 2
) (
  input  logic             rst,
  input  logic             rec_clk,
  input  logic             rise_sel,
  input  logic [LANES-1:0] p_in,
  input  logic [LANES-1:0] n_in,
  output logic [LANES-1:0] p_ret,
  output logic [LANES-1:0] n_ret
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic rise_p_q, rise_n_q, fall_p_q, fall_n_q;

    always_ff @(posedge rec_clk) begin
      if (rst) begin
        rise_p_q <= 1'b0;
        rise_n_q <= 1'b0;
      end else begin
        rise_p_q <= p_in[g];
        rise_n_q <= n_in[g];
      end
    end

    always_ff @(negedge rec_clk) begin
      if (rst) begin
        fall_p_q <= 1'b0;
        fall_n_q <= 1'b0;
      end else begin
        fall_p_q <= p_in[g];
        fall_n_q <= n_in[g];
      end
    end

    assign p_ret[g] = rise_sel ? rise_p_q : fall_p_q;
    assign n_ret[g] = rise_sel ? rise_n_q : fall_n_q;
  end
endmodule

// File: rtl/rxr_alarm_sync.sv
module rxr_alarm_sync #(
  parameter int STAGES = 2
) (
  input  logic rst,
  input  logic ref_clk,
  input  logic alarm_in,
  input  logic shut_en,
  output logic squelch
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sync_q;
  logic          squelch_q;

  always_ff @(posedge ref_clk) begin
    if (rst) begin
      sync_q    <= '0;
      squelch_q <= 1'b0;
    end else begin
      sync_q[0] <= alarm_in;
      for (int i = 1; i < STAGES; i++) sync_q[i] <= sync_q[i-1];
      squelch_q <= shut_en & sync_q[LAST];
    end
  end

  assign squelch = squelch_q;
endmodule

// File: rtl/rxr_clk_switch.sv
module rxr_clk_switch (
  input  logic rst,
  input  logic rec_clk,
  input  logic ref_clk,
  input  logic use_ref,
  output logic rec_en,
  output logic ref_en,
  output logic clk_out
);
  logic rec_arm_q, rec_en_q;
  logic ref_arm_q, ref_en_q;

  // first stage on the rising edge, enable updated on the falling edge
  always_ff @(posedge rec_clk) begin
    if (rst) rec_arm_q <= 1'b0;
    else     rec_arm_q <= ~use_ref & ~ref_en_q;
  end

  always_ff @(negedge rec_clk) begin
    if (rst) rec_en_q <= 1'b0;
    else     rec_en_q <= rec_arm_q;
  end

  always_ff @(posedge ref_clk) begin
    if (rst) ref_arm_q <= 1'b0;
    else     ref_arm_q <= use_ref & ~rec_en_q;
  end

  always_ff @(negedge ref_clk) begin
    if (rst) ref_en_q <= 1'b0;
    else     ref_en_q <= ref_arm_q;
  end

  assign rec_en  = rec_en_q;
  assign ref_en  = ref_en_q;
  assign clk_out = (rec_clk & rec_en_q) | (ref_clk & ref_en_q);
endmodule

// File: rtl/rx_retime_squelch.sv
module rx_retime_squelch
  import rxr_pkg::*;
#(
  parameter int LANES       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             rst,
  input  logic             rec_clk,
  input  logic             ref_clk,
  input  logic [CFG_W-1:0] cfg_reg,
  input  logic             dlos_in,
  input  logic [LANES-1:0] rail_p_in,
  input  logic [LANES-1:0] rail_n_in,
  output logic [LANES-1:0] rail_p_out,
  output logic [LANES-1:0] rail_n_out,
  output logic             clk_out
);
  rxr_ctl_t         ctl;
  logic [LANES-1:0] p_ret, n_ret;
  logic             squelch;
  logic             rec_en, ref_en;
  logic             cfg_spare_unused;

  assign ctl              = rxr_decode(cfg_reg);
  assign cfg_spare_unused = ^cfg_reg[LEVEL_BIT-1:0];

  rxr_edge_capture #(.LANES(LANES)) cap_i (
    .rst      (rst),
    .rec_clk  (rec_clk),
    .rise_sel (ctl.rise_sel),
    .p_in     (rail_p_in),
    .n_in     (rail_n_in),
    .p_ret    (p_ret),
    .n_ret    (n_ret)
  );

  rxr_alarm_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .rst      (rst),
    .ref_clk  (ref_clk),
    .alarm_in (dlos_in),
    .shut_en  (ctl.shut_en),
    .squelch  (squelch)
  );

  rxr_clk_switch sw_i (
    .rst     (rst),
    .rec_clk (rec_clk),
    .ref_clk (ref_clk),
    .use_ref (squelch),
    .rec_en  (rec_en),
    .ref_en  (ref_en),
    .clk_out (clk_out)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign rail_p_out[g] = squelch ? ctl.idle_high : p_ret[g];
    assign rail_n_out[g] = squelch ? ctl.idle_high : n_ret[g];
  end
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker
  import rxr_pkg::*;
#(
  parameter int LANES = 2
) (
  input logic             rst,
  input logic             rec_clk,
  input logic             ref_clk,
  input logic [CFG_W-1:0] cfg_reg,
  input logic             dlos_in,
  input logic [LANES-1:0] rail_p_in,
  input logic [LANES-1:0] rail_n_in,
  input logic [LANES-1:0] rail_p_out,
  input logic [LANES-1:0] rail_n_out,
  input logic             squelch,
  input logic             rec_en,
  input logic             ref_en
);
  // R1: rising-edge capture
  a_r1_rise_capture: assert property (@(posedge rec_clk) disable iff (rst)
    (cfg_reg[EDGE_BIT] && !squelch) |=>
      (squelch || !cfg_reg[EDGE_BIT] ||
       (rail_p_out == $past(rail_p_in) && rail_n_out == $past(rail_n_in))));

  // R2: falling-edge capture
  a_r2_fall_capture: assert property (@(negedge rec_clk) disable iff (rst)
    (!cfg_reg[EDGE_BIT] && !squelch) |=>
      (squelch || cfg_reg[EDGE_BIT] ||
       (rail_p_out == $past(rail_p_in) && rail_n_out == $past(rail_n_in))));

  // R3, R7: alarm three edges back forces the idle level
  a_r3_squelch_level: assert property (@(posedge ref_clk) disable iff (rst)
    (!$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3) &&
     $past(dlos_in, 3) && $past(cfg_reg[SHUT_BIT], 1)) |->
      (rail_p_out == {LANES{cfg_reg[LEVEL_BIT]}} &&
       rail_n_out == {LANES{cfg_reg[LEVEL_BIT]}}));

  // R5: no squelch while shut-down is clear
  a_r5_no_squelch: assert property (@(posedge ref_clk) disable iff (rst)
    !$past(cfg_reg[SHUT_BIT]) |-> !squelch);

  // R6: never both clock sources enabled
  a_r6_single_source: assert property (@(posedge ref_clk) disable iff (rst)
    $onehot0({rec_en, ref_en}));
endmodule

bind rx_retime_squelch rxr_checker #(.LANES(LANES)) chk_i (
  .rst        (rst),
  .rec_clk    (rec_clk),
  .ref_clk    (ref_clk),
  .cfg_reg    (cfg_reg),
  .dlos_in    (dlos_in),
  .rail_p_in  (rail_p_in),
  .rail_n_in  (rail_n_in),
  .rail_p_out (rail_p_out),
  .rail_n_out (rail_n_out),
  .squelch    (squelch),
  .rec_en     (rec_en),
  .ref_en     (ref_en)
);

// File: tb/rx_retime_squelch_tb_top.sv
`timescale 1ns/1ps
module rx_retime_squelch_tb_top;
  localparam int LANES = 2;

  logic             rst = 1'b1;
  logic             rec_clk = 1'b0;
  logic             ref_clk = 1'b0;
  logic [7:0]       cfg_reg = 8'h00;
  logic             dlos_in = 1'b0;
  logic [LANES-1:0] rail_p_in = '1;
  logic [LANES-1:0] rail_n_in = '1;
  logic [LANES-1:0] rail_p_out, rail_n_out;
  logic             clk_out;

  int checks = 0;
  int errors = 0;
  int edge_cnt = 0;
  int short_pulses = 0;
  bit mon_en = 0;
  bit have_last = 0;
  realtime last_t = 0.0;

  always #2.5 ref_clk = ~ref_clk;  // 200 MHz
  always #4.0 rec_clk = ~rec_clk;  // recovered clock, distinct rate

  rx_retime_squelch #(.LANES(LANES)) dut_i (
    .rst(rst), .rec_clk(rec_clk), .ref_clk(ref_clk), .cfg_reg(cfg_reg),
    .dlos_in(dlos_in), .rail_p_in(rail_p_in), .rail_n_in(rail_n_in),
    .rail_p_out(rail_p_out), .rail_n_out(rail_n_out), .clk_out(clk_out)
  );

  always @(posedge clk_out) edge_cnt++;

  // R6: pulse width monitor, shortest half-period is 2.5 ns
  always @(clk_out) begin
    if (mon_en) begin
      if (have_last && ($realtime - last_t) < 2.4) short_pulses++;
      last_t = $realtime;
      have_last = 1;
    end
  end

  // fields: edge, A_p, A_n, B_p, B_n, exp_p, exp_n
  localparam logic [12:0] VECS [0:7] = '{
    13'b1_01_10_10_01_01_10,
    13'b0_01_10_10_01_10_01,
    13'b1_11_00_00_11_11_00,
    13'b0_11_00_00_11_00_11,
    13'b1_00_00_11_11_00_00,
    13'b0_00_00_11_11_11_11,
    13'b1_10_11_01_00_10_11,
    13'b0_01_01_11_10_11_10
  };

  function automatic logic [7:0] mk_cfg(input bit shut, input bit rise,
                                        input bit lvl, input logic [4:0] spare);
    return {shut, rise, lvl, spare};
  endfunction

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_range(input string tag, input int act, input int lo,
                             input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  // drive A across the rising edge, B across the falling edge, then sample
  task automatic run_vec(input logic [12:0] v, input string tag);
    @(negedge rec_clk); #1;
    rail_p_in = v[11:10]; rail_n_in = v[9:8];
    @(posedge rec_clk); #1;
    rail_p_in = v[7:6];   rail_n_in = v[5:4];
    @(negedge rec_clk); #1;
    check({tag, " p"}, 32'(rail_p_out), 32'(v[3:2]));
    check({tag, " n"}, 32'(rail_n_out), 32'(v[1:0]));
  endtask

  task automatic count_edges(output int n);
    int start;
    start = edge_cnt;
    #80;
    n = edge_cnt - start;
  endtask

  task automatic ref_wait(input int n);
    repeat (n) @(posedge ref_clk);
    #1;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    // R8: reset state
    ref_wait(4);
    count_edges(n);
    check_range("R8 clock held low in reset", n, 0, 0);
    check("R8 rail_p in reset", 32'(rail_p_out), 0);
    check("R8 rail_n in reset", 32'(rail_n_out), 0);
    rst = 1'b0;
    ref_wait(10);
    mon_en = 1;
    count_edges(n);
    check_range("R8 clock follows rec_clk after reset", n, 9, 11);

    // R1/R2: vector table
    for (int i = 0; i < 8; i++) begin
      cfg_reg = mk_cfg(1'b0, VECS[i][12], 1'b0, 5'd0);
      run_vec(VECS[i], VECS[i][12] ? "R1 rising capture" : "R2 falling capture");
    end

    // R9: spare bits set, same results
    cfg_reg = mk_cfg(1'b0, 1'b1, 1'b0, 5'h1f);
    run_vec(VECS[0], "R9 spare bits rising");
    cfg_reg = mk_cfg(1'b0, 1'b0, 1'b0, 5'h15);
    run_vec(VECS[3], "R9 spare bits falling");

    // R5: alarm with shut-down clear
    dlos_in = 1'b1;
    ref_wait(6);
    cfg_reg = mk_cfg(1'b0, 1'b1, 1'b1, 5'd0);
    run_vec(VECS[2], "R5 alarm ignored rising");
    cfg_reg = mk_cfg(1'b0, 1'b0, 1'b1, 5'd0);
    run_vec(VECS[1], "R5 alarm ignored falling");
    count_edges(n);
    check_range("R5 clock stays on rec_clk", n, 9, 11);
    dlos_in = 1'b0;
    ref_wait(6);

    // R7: assertion latency (idle high, inputs low)
    rail_p_in = '0; rail_n_in = '0;
    cfg_reg = mk_cfg(1'b1, 1'b1, 1'b1, 5'd0);
    ref_wait(6);
    @(posedge ref_clk); #1;
    dlos_in = 1'b1;
    ref_wait(2);
    check("R7 no squelch at second edge", 32'(rail_p_out), 32'(2'b00));
    ref_wait(1);
    check("R7 squelch at third edge", 32'(rail_p_out), 32'(2'b11));

    // R3/R4: squelched levels and clock
    ref_wait(20);
    check("R3 idle high n", 32'(rail_n_out), 32'(2'b11));
    rail_p_in = '1; rail_n_in = '1;
    cfg_reg = mk_cfg(1'b1, 1'b0, 1'b0, 5'd0);
    #6;
    check("R3 idle low p", 32'(rail_p_out), 32'(2'b00));
    check("R3 idle low n", 32'(rail_n_out), 32'(2'b00));
    cfg_reg = mk_cfg(1'b1, 1'b0, 1'b0, 5'h0a);
    #6;
    check("R9 spare bits in squelch", 32'(rail_p_out), 32'(2'b00));
    count_edges(n);
    check_range("R4 clock on ref_clk", n, 15, 17);

    // R7: release latency (idle low, inputs high)
    @(posedge ref_clk); #1;
    dlos_in = 1'b0;
    ref_wait(2);
    check("R7 still squelched at second edge", 32'(rail_p_out), 32'(2'b00));
    ref_wait(1);
    check("R7 released at third edge", 32'(rail_p_out), 32'(2'b11));
    ref_wait(20);
    count_edges(n);
    check_range("R4 clock back on rec_clk", n, 9, 11);

    // R6: another round trip, then pulse width verdict
    dlos_in = 1'b1;
    ref_wait(30);
    dlos_in = 1'b0;
    ref_wait(30);
    check("R6 short clock pulses", 32'(short_pulses), 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule